// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block generates one reset for a processor subsystem. It merges four inputs, each already digitized by an external comparator and high when its supply is good, with an active-low manual reset button and a watchdog input. While any supply is bad, or while the manual button is held, reset is asserted. Once every condition is good again, reset is held for one more timeout period before it releases. The timeout can be 50, 100, 200 or 400 ms.

Time is measured in millisecond ticks taken from a free-running prescaler on the system clock. A simulation can therefore shrink every period by lowering `TICK_CYCLES`. The manual reset and watchdog inputs are both brought in through two-flop synchronizers. The manual reset then passes a glitch filter. The watchdog input goes to an edge detector that accepts rising and falling edges alike.

When the watchdog input shows no edge for `WDOG_MS` ticks, the watchdog fires one reset pulse of a full timeout period. The watchdog counter restarts after that pulse, so a stalled processor receives repeated pulses. A static enable input switches the watchdog off.

Top module: `rst_supervisor`

## Requirements
- R1: A low level on any bit of `supply_ok` asserts reset at the first clock edge that samples it, and reset stays asserted while that bit is low.
- R2: Reset releases only after all causes are gone (every `supply_ok` bit high, manual reset not accepted) and a timeout period of millisecond ticks has elapsed. The period is counted from the last clock in which a cause was present. The release falls on the tick that completes the period.
- R3: `tsel` picks the period as `BASE_MS << tsel` ticks: 0 gives 50, 1 gives 100, 2 gives 200 and 3 gives 400 ms. The value 2 is the nominal setting.
- R4: A low level on `mr_n` that stays low for `FILT_CYCLES` consecutive samples after the two-flop synchronizer asserts reset and keeps it asserted while `mr_n` stays low. After `mr_n` goes high, release follows R2.
- R5: A low pulse on `mr_n` shorter than `FILT_CYCLES` clocks has no effect on the reset output.
- R6: With `wd_en` high, the watchdog expires when the synchronized `wdi` shows no edge for `WDOG_MS` consecutive ticks. Either edge direction restarts the count. The count is also held at zero while reset is asserted or while manual reset is accepted. Regular toggling of `wdi` never causes a reset.
- R7: While the synchronous block reset `rst_n` is low, reset is asserted. After `rst_n` goes high, release follows R2.
- R8: Each watchdog expiry asserts reset for exactly one timeout period (`BASE_MS << tsel` ticks times `TICK_CYCLES` clocks) and then releases it. If `wdi` stays idle, later expiries repeat the pulse.
- R9: While `wd_en` is low, the watchdog counter stays at zero and never causes a reset.
- R10: If a supply bit drops during a watchdog-triggered pulse, the timeout restarts and runs a full period from the moment that bit returns high.
- R11: With `ACTIVE_HIGH` = 0, `rst_out` is low while reset is asserted. With `ACTIVE_HIGH` = 1, it is high while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| supply_ok | input | N_SUP | Supply-good flags from the comparators, high = good |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wdi | input | 1 | Watchdog kick input, asynchronous, either edge counts |
| wd_en | input | 1 | Static watchdog enable |
| tsel | input | 2 | Timeout select, period = BASE_MS << tsel ms |
| rst_out | output | 1 | Reset output, polarity set by ACTIVE_HIGH |

## Verification
The embedded properties check four things on every cycle:
- a bad supply always asserts reset on the next edge;
- reset never falls while a cause is still present;
- the filter accepts manual reset only after a low synchronized sample;
- the watchdog count stays within its limit and stays at zero while it is disabled.

Some behaviours can only be shown by the bench's scenarios against its behavioural model. These are the exact period for each select value, the rejection of short manual pulses, the watchdog expiry delay and exact pulse length, repeated pulses, and the restart of the period when a supply drops in the middle of a watchdog pulse.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int N_SUP       = 4,
  parameter int TICK_CYCLES = 100000,
  parameter int BASE_MS     = 50,
  parameter int WDOG_MS     = 1600,
  parameter int FILT_CYCLES = 100,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SUP-1:0] supply_ok,
  input  logic             mr_n,
  input  logic             wdi,
  input  logic             wd_en,
  input  logic [1:0]       tsel,
  output logic             rst_out
);
  localparam int TW  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int MSW = $clog2(BASE_MS * 8);
  localparam int WW  = $clog2(WDOG_MS + 1);
  localparam int FW  = $clog2(FILT_CYCLES + 1);

  logic [TW-1:0]  pre;
  logic [1:0]     mr_sy;
  logic [2:0]     wd_sy;
  logic [FW-1:0]  flt;
  logic [WW-1:0]  wd_cnt;
  logic [MSW-1:0] ms_cnt;
  logic           rst_act;

  wire tick     = (pre == TW'(TICK_CYCLES - 1));
  wire mr_act   = (flt == FW'(FILT_CYCLES));
  wire wd_edge  = wd_sy[2] ^ wd_sy[1];
  wire cause    = ~(&supply_ok) | mr_act;
  wire wd_clr   = ~wd_en | rst_act | mr_act | wd_edge;
  wire wd_exp   = ~wd_clr & tick & (wd_cnt == WW'(WDOG_MS - 1));
  wire [MSW-1:0] per_m1 = (MSW'(BASE_MS) << tsel) - MSW'(1);

  assign rst_out = ACTIVE_HIGH ? rst_act : ~rst_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      mr_sy <= 2'b11;
      wd_sy <= 3'b000;
    end else begin
      pre   <= tick ? '0 : pre + TW'(1);
      mr_sy <= {mr_sy[0], mr_n};
      wd_sy <= {wd_sy[1:0], wdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mr_sy[1]) flt <= '0;
    else if (!mr_act)       flt <= flt + FW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wd_clr) wd_cnt <= '0;
    else if (tick)        wd_cnt <= wd_exp ? '0 : wd_cnt + WW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cause || wd_exp) begin
      rst_act <= 1'b1;
      ms_cnt  <= '0;
    end else if (rst_act && tick) begin
      if (ms_cnt == per_m1) begin
        rst_act <= 1'b0;
        ms_cnt  <= '0;
      end else begin
        ms_cnt <= ms_cnt + MSW'(1);
      end
    end
  end

  p_supply_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(&supply_ok) |=> rst_act);
  p_no_early_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> ($past(&supply_ok) && !$past(mr_act)));
  p_mr_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_act) |-> $past(!mr_sy[1]));
  p_wd_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < WW'(WDOG_MS));
  p_wd_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && $past(!wd_en)) |-> (wd_cnt == '0));
  p_mr_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mr_act |=> rst_act);
endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int T    = 4;
  localparam int BASE = 50;
  localparam int WD   = 1600;
  localparam int FILT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] supply_ok = 4'hF;
  logic mr_n = 1'b1, wdi = 1'b0, wd_en = 1'b0;
  logic [1:0] tsel = 2'd0;
  logic rst_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, cmp_on = 0;

  always #5 clk = ~clk;

  rst_supervisor #(.N_SUP(4), .TICK_CYCLES(T), .BASE_MS(BASE), .WDOG_MS(WD),
                   .FILT_CYCLES(FILT), .ACTIVE_HIGH(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wdi(wdi),
    .wd_en(wd_en), .tsel(tsel), .rst_out(rst_out));

  // behavioural reference: delay lines, run lengths and a countdown
  int mq[$], wq[$];
  int phase, lowrun, wdage, rem;
  bit in_rst;

  function automatic int per_ticks(input logic [1:0] s);
    return BASE * (1 << s);
  endfunction

  always @(posedge clk) begin
    int m2, w2, wprev, nlow, nage, nrem;
    bit tk, mra, edg, cause, clr, exp_w, nrst;
    if (!rst_n) begin
      mq = {1, 1}; wq = {0, 0, 0};
      phase = 0; lowrun = 0; wdage = 0; in_rst = 1; rem = per_ticks(tsel);
    end else begin
      m2 = mq[0]; w2 = wq[1]; wprev = wq[0];
      tk = (phase == T - 1);
      mra = (lowrun >= FILT);
      edg = (w2 != wprev);
      cause = !(&supply_ok) || mra;
      clr = !wd_en || in_rst || mra || edg;
      exp_w = !clr && tk && (wdage == WD - 1);
      nage = clr ? 0 : (tk ? (exp_w ? 0 : wdage + 1) : wdage);
      nrst = in_rst; nrem = rem;
      if (cause || exp_w) begin
        nrst = 1; nrem = per_ticks(tsel);
      end else if (in_rst && tk) begin
        nrem = rem - 1;
        if (nrem == 0) nrst = 0;
      end
      nlow = (m2 != 0) ? 0 : ((lowrun < FILT) ? lowrun + 1 : FILT);
      phase = (phase + 1) % T;
      lowrun = nlow; wdage = nage; in_rst = nrst; rem = nrem;
      void'(mq.pop_front()); mq.push_back(int'(mr_n));
      void'(wq.pop_front()); wq.push_back(int'(wdi));
    end
    cmp_on = 1;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_cmp++;
      if (rst_out !== ~in_rst) begin
        n_bad++;
        $display("FAIL model R1/R2/R6/R8 t=%0t actual=%b expected=%b", $time, rst_out, ~in_rst);
      end
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_out);
    n_cmp++;
    if (rst_out !== exp_out) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, rst_out, exp_out);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic quiet(input string req, input int n, input bit toggle);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (toggle && (i % 1000 == 0)) wdi = ~wdi;
      @(negedge clk);
      if (rst_out === 1'b0) seen++;
    end
    chk_rng(req, seen, 0, 0);
  endtask

  task automatic period_check(input string req, input logic [1:0] s);
    int p = per_ticks(s) * T;
    wcyc(p - 10); chk(req, 1'b0);
    wcyc(20);     chk(req, 1'b1);
  endtask

  initial begin
    int n;
    wcyc(5);
    chk("R7 reset state", 1'b0);
    chk("R11 active-low", 1'b0);
    rst_n = 1'b1;
    period_check("R7 R2 R3 sel0 release", 2'd0);

    for (int k = 0; k < 4; k++) begin
      tsel = 2'(k);
      supply_ok[k] = 1'b0;
      wcyc(2);
      chk("R1 supply low", 1'b0);
      wcyc(30);
      chk("R1 held", 1'b0);
      supply_ok[k] = 1'b1;
      period_check("R2 R3 period select", 2'(k));
    end

    tsel = 2'd0;
    mr_n = 1'b0; wcyc(8); mr_n = 1'b1;
    quiet("R5 glitch ignored", 300, 0);
    mr_n = 1'b0; wcyc(150);
    chk("R4 manual accepted", 1'b0);
    mr_n = 1'b1;
    wcyc(3);
    period_check("R4 manual release", 2'd0);

    wd_en = 1'b1;
    quiet("R6 toggling keeps quiet", 10000, 1);
    n = 0;
    while (rst_out === 1'b1 && n < 9000) begin @(negedge clk); n++; end
    chk_rng("R6 expiry delay", n, WD * T - 1000 - 10, WD * T - 1000 + 10);
    n = 0;
    while (rst_out === 1'b0 && n < 5000) begin @(negedge clk); n++; end
    chk_rng("R8 pulse length", n, BASE * T, BASE * T);
    n = 0;
    while (rst_out === 1'b1 && n < 9000) begin @(negedge clk); n++; end
    chk_rng("R8 repeat pulse", n, WD * T - 10, WD * T + 10);
    wcyc(100);
    supply_ok[2] = 1'b0; wcyc(5); supply_ok[2] = 1'b1;
    wcyc(BASE * T - 10);
    chk("R10 restart after supply", 1'b0);
    wcyc(20);
    chk("R10 release", 1'b1);

    wd_en = 1'b0;
    quiet("R9 watchdog disabled", 8000, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule